// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is a byte-wide arithmetic and logic unit whose result is produced combinationally from two operands and a five-bit operation code. Beside the datapath sits a four-bit condition register holding carry (C), sign (S), zero (Z) and overflow (V). The register is written on a rising clock edge only while the load strobe is high, so a controller can compute a result at any time and commit the condition bits only for the operations it chooses.

The datapath covers two's-complement addition and subtraction (with and without the stored carry), increment, decrement and negation. It also covers bitwise AND, OR, XOR, complement and clear, and eight single-position shifts: logical, arithmetic, plain rotates and rotates through the stored carry. Three codes operate on the carry bit alone. Overflow is formed from the carries into and out of the top adder stage. Equality of two bytes is therefore read from Z after an XOR, and a single bit is tested by AND-masking and reading Z.

Top module: `alu_status_unit`

## Requirements
- R1: While rst_n is low, all four condition bits read 0.
- R2: The condition bits change only on a rising clock edge with flag_load high, and hold otherwise. alu_out follows the inputs without waiting for a clock.
- R3: The add group uses these opcodes: ADD=0 (A+B), ADC=1 (A+B+C), SUB=2 (A+~B+1), SBB=3 (A+~B+C). Each result is the low 8 bits of its sum. C takes the carry out of bit 7, so after a subtract C=1 means no borrow.
- R4: For opcodes 0 to 6, V equals the carry into bit 7 XOR the carry out of bit 7. V is therefore 1 exactly when the signed result leaves the range -128..+127.
- R5: For every opcode from 0 to 19, S equals alu_out bit 7, and Z is 1 exactly when all eight bits of alu_out are 0.
- R6: INC=4 gives A+1. DEC=5 gives A+0xFF, so C=1 unless A is 0. NEG=6 gives 0+~A+1, so C=1 only for A=0, and V=1 only for A=0x80.
- R7: The logic codes are AND=7, OR=8, XOR=9, NOT=10 (~A) and CLR=11 (result 0). Each of them clears V and leaves C unchanged.
- R8: XOR of A and B sets Z exactly when A equals B. AND of A with a one-hot mask sets Z exactly when the masked bit of A is 0.
- R9: The non-rotating shifts are SHR=12 (zero into bit 7), SHL=13 (zero into bit 0), SAR=14 (bit 7 kept) and SAL=15 (same result as SHL). Each puts the bit shifted out into C. V=0, except that SAL sets V when bit 7 of the result differs from bit 7 of A.
- R10: The rotates are ROR=16, ROL=17, RCR=18 and RCL=19. ROR and ROL wrap the outgoing bit around. RCR and RCL shift the old C in and move the outgoing bit into C. V=0 for all four.
- R11: The carry codes are CLC=20 (C=0), STC=21 (C=1) and CMC=22 (C inverted). Each leaves S, Z and V unchanged and drives alu_out = A.
- R12: Opcodes 23 to 31 drive alu_out = A and leave all four condition bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the condition register |
| rst_n | input | 1 | Asynchronous active-low reset of the condition bits |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| op_code | input | 5 | Operation select, encodings in R3 to R12 |
| flag_load | input | 1 | Commit the new condition bits at the next rising edge |
| alu_out | output | 8 | Combinational result |
| flag_c | output | 1 | Stored carry |
| flag_s | output | 1 | Stored sign |
| flag_z | output | 1 | Stored zero |
| flag_v | output | 1 | Stored overflow |

## Verification
The add and subtract codes are driven with operand pairs that each produce a different condition-bit pattern:
- 0x7F+0x01 gives overflow without carry.
- 0xFF+0x01 gives carry without overflow.
- 0x80+0x80 gives both.
- 0x80-0x01 overflows in the subtract direction.

Pairs with equal and unequal operands separate the zero test from the sign test. Chained operations show that the stored carry really feeds ADC, SBB and the through-carry rotates: 0x01 rotated right through carry gives 0x00 when C is clear and 0x80 when C is set. Negating 0x80 against 0x01 and 0x00, and shifting 0x40 against 0xC0 left arithmetically, isolate the special overflow rules. Preloading V=1 and C=1 before a logic operation shows that V is cleared while C is left alone.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
        OP_INC = 5'd4,  OP_DEC = 5'd5,  OP_NEG = 5'd6,
        OP_AND = 5'd7,  OP_OR  = 5'd8,  OP_XOR = 5'd9,  OP_NOT = 5'd10,
        OP_CLR = 5'd11,
        OP_SHR = 5'd12, OP_SHL = 5'd13, OP_SAR = 5'd14, OP_SAL = 5'd15,
        OP_ROR = 5'd16, OP_ROL = 5'd17, OP_RCR = 5'd18, OP_RCL = 5'd19,
        OP_CLC = 5'd20, OP_STC = 5'd21, OP_CMC = 5'd22
    } op_e;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
        logic v;
    } flags_t;

    function automatic logic op_is_arith(input op_e o);
        return (o inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC, OP_NEG});
    endfunction

    function automatic logic op_is_logic(input op_e o);
        return (o inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_CLR});
    endfunction

    function automatic logic op_is_shift(input op_e o);
        return (o inside {OP_SHR, OP_SHL, OP_SAR, OP_SAL,
                          OP_ROR, OP_ROL, OP_RCR, OP_RCL});
    endfunction

endpackage

// File: rtl/alu_ripple_adder.sv
// Ripple-carry adder that exposes both the carry out of the top stage
// and the carry into it, so overflow can be formed from the two.
module alu_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    input  logic         add_cin,
    output logic [W-1:0] add_sum,
    output logic         add_cout,
    output logic         add_cmsb
);
    logic [W:0] chain;

    assign chain[0] = add_cin;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign add_sum[i]   = add_x[i] ^ add_y[i] ^ chain[i];
        assign chain[i+1]   = (add_x[i] & add_y[i]) | (chain[i] & (add_x[i] ^ add_y[i]));
    end

    assign add_cout = chain[W];
    assign add_cmsb = chain[W-1];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_status_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          bw_op,
    input  logic [W-1:0] bw_a,
    input  logic [W-1:0] bw_b,
    output logic [W-1:0] bw_res
);
    always_comb begin
        unique case (bw_op)
            OP_AND:  bw_res = bw_a & bw_b;
            OP_OR:   bw_res = bw_a | bw_b;
            OP_XOR:  bw_res = bw_a ^ bw_b;
            OP_NOT:  bw_res = ~bw_a;
            OP_CLR:  bw_res = '0;
            default: bw_res = bw_a;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_status_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          sh_op,
    input  logic [W-1:0] sh_a,
    input  logic         sh_cin,
    output logic [W-1:0] sh_res,
    output logic         sh_cout,
    output logic         sh_vout
);
    localparam int MSB = W - 1;

    always_comb begin
        sh_res  = sh_a;
        sh_cout = sh_cin;
        sh_vout = 1'b0;
        unique case (sh_op)
            OP_SHR: begin sh_res = {1'b0, sh_a[MSB:1]};       sh_cout = sh_a[0];   end
            OP_SHL: begin sh_res = {sh_a[MSB-1:0], 1'b0};     sh_cout = sh_a[MSB]; end
            OP_SAR: begin sh_res = {sh_a[MSB], sh_a[MSB:1]};  sh_cout = sh_a[0];   end
            OP_SAL: begin
                sh_res  = {sh_a[MSB-1:0], 1'b0};
                sh_cout = sh_a[MSB];
                sh_vout = sh_a[MSB] ^ sh_a[MSB-1];
            end
            OP_ROR: begin sh_res = {sh_a[0], sh_a[MSB:1]};    sh_cout = sh_a[0];   end
            OP_ROL: begin sh_res = {sh_a[MSB-1:0], sh_a[MSB]}; sh_cout = sh_a[MSB]; end
            OP_RCR: begin sh_res = {sh_cin, sh_a[MSB:1]};     sh_cout = sh_a[0];   end
            OP_RCL: begin sh_res = {sh_a[MSB-1:0], sh_cin};   sh_cout = sh_a[MSB]; end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [OP_W-1:0]   op_code,
    input  logic              flag_load,
    output logic [DATA_W-1:0] alu_out,
    output logic              flag_c,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_v
);
    localparam int MSB = DATA_W - 1;

    op_e               op;
    flags_t            flags_q, flags_d;
    logic [DATA_W-1:0] add_x, add_y, add_sum, bw_res, sh_res;
    logic              add_cin, add_cout, add_cmsb, sh_cout, sh_vout;

    assign op = op_e'(op_code);

    // Operand steering for the shared adder
    always_comb begin
        add_x   = opnd_a;
        add_y   = opnd_b;
        add_cin = 1'b0;
        unique case (op)
            OP_ADC: add_cin = flags_q.c;
            OP_SUB: begin add_y = ~opnd_b; add_cin = 1'b1;      end
            OP_SBB: begin add_y = ~opnd_b; add_cin = flags_q.c; end
            OP_INC: begin add_y = '0;      add_cin = 1'b1;      end
            OP_DEC: begin add_y = '1;      add_cin = 1'b0;      end
            OP_NEG: begin add_x = '0; add_y = ~opnd_a; add_cin = 1'b1; end
            default: ;
        endcase
    end

    alu_ripple_adder #(.W(DATA_W)) u_adder (
        .add_x    (add_x),
        .add_y    (add_y),
        .add_cin  (add_cin),
        .add_sum  (add_sum),
        .add_cout (add_cout),
        .add_cmsb (add_cmsb)
    );

    alu_bitwise #(.W(DATA_W)) u_bitwise (
        .bw_op  (op),
        .bw_a   (opnd_a),
        .bw_b   (opnd_b),
        .bw_res (bw_res)
    );

    alu_shifter #(.W(DATA_W)) u_shifter (
        .sh_op   (op),
        .sh_a    (opnd_a),
        .sh_cin  (flags_q.c),
        .sh_res  (sh_res),
        .sh_cout (sh_cout),
        .sh_vout (sh_vout)
    );

    // Result select
    always_comb begin
        if (op_is_arith(op))      alu_out = add_sum;
        else if (op_is_logic(op)) alu_out = bw_res;
        else if (op_is_shift(op)) alu_out = sh_res;
        else                      alu_out = opnd_a;
    end

    // Next condition bits
    always_comb begin
        flags_d = flags_q;
        if (op_is_arith(op)) begin
            flags_d.c = add_cout;
            flags_d.v = add_cout ^ add_cmsb;
            flags_d.s = alu_out[MSB];
            flags_d.z = (alu_out == '0);
        end else if (op_is_logic(op)) begin
            flags_d.v = 1'b0;
            flags_d.s = alu_out[MSB];
            flags_d.z = (alu_out == '0);
        end else if (op_is_shift(op)) begin
            flags_d.c = sh_cout;
            flags_d.v = sh_vout;
            flags_d.s = alu_out[MSB];
            flags_d.z = (alu_out == '0);
        end else begin
            unique case (op)
                OP_CLC:  flags_d.c = 1'b0;
                OP_STC:  flags_d.c = 1'b1;
                OP_CMC:  flags_d.c = ~flags_q.c;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flags_q <= '0;
        else if (flag_load) flags_q <= flags_d;
    end

    assign flag_c = flags_q.c;
    assign flag_s = flags_q.s;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
    import alu_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [OP_W-1:0]   op_code,
    input logic              flag_load,
    input logic [DATA_W-1:0] alu_out,
    input logic              flag_c,
    input logic              flag_s,
    input logic              flag_z,
    input logic              flag_v
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide_sum;
    logic            is_add, is_logic, is_carry_op, is_reserved, sets_sz;

    assign wide_sum    = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign is_add      = (op_code == OP_ADD);
    assign is_logic    = op_is_logic(op_e'(op_code));
    assign is_carry_op = (op_code >= 5'd20) && (op_code <= 5'd22);
    assign is_reserved = (op_code > 5'd22);
    assign sets_sz     = (op_code <= 5'd19);

    // R2
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |=> $stable({flag_c, flag_s, flag_z, flag_v}));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && is_add) |=> (flag_c == $past(wide_sum[DATA_W])));

    // R4
    add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && is_add) |=>
        (flag_v == ($past(opnd_a[MSB]) == $past(opnd_b[MSB]) &&
                    $past(alu_out[MSB]) != $past(opnd_a[MSB]))));

    // R5
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && sets_sz) |=>
        (flag_z == ($past(alu_out) == '0)) && (flag_s == $past(alu_out[MSB])));

    // R7
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && is_logic) |=> (!flag_v && flag_c == $past(flag_c)));

    // R8
    xor_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && op_code == OP_XOR && opnd_a == opnd_b) |=> flag_z);

    // R11
    carry_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && is_carry_op) |=> $stable({flag_s, flag_z, flag_v}));

    // R12
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_reserved |-> (alu_out == opnd_a));

    // R12
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && is_reserved) |=> $stable({flag_c, flag_s, flag_z, flag_v}));
endmodule

bind alu_status_unit alu_status_chk #(.DATA_W(DATA_W)) u_status_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .flag_load (flag_load),
    .alu_out   (alu_out),
    .flag_c    (flag_c),
    .flag_s    (flag_s),
    .flag_z    (flag_z),
    .flag_v    (flag_v)
);

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] ADD = 5'd0,  ADC = 5'd1,  SUB = 5'd2,  SBB = 5'd3;
    localparam logic [4:0] INC = 5'd4,  DEC = 5'd5,  NEG = 5'd6;
    localparam logic [4:0] AND = 5'd7,  OR_ = 5'd8,  XOR = 5'd9,  NOT = 5'd10, CLR = 5'd11;
    localparam logic [4:0] SHR = 5'd12, SHL = 5'd13, SAR = 5'd14, SAL = 5'd15;
    localparam logic [4:0] ROR = 5'd16, ROL = 5'd17, RCR = 5'd18, RCL = 5'd19;
    localparam logic [4:0] CLC = 5'd20, STC = 5'd21, CMC = 5'd22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [4:0] op_code = '0;
    logic       flag_load = 1'b0;
    logic [7:0] alu_out;
    logic       flag_c, flag_s, flag_z, flag_v;
    logic [3:0] flags_now;
    logic [7:0] res_seen;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    assign flags_now = {flag_c, flag_s, flag_z, flag_v};

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_status_unit i_alu_status_unit (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_code(op_code), .flag_load(flag_load), .alu_out(alu_out),
        .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z), .flag_v(flag_v)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation; result sampled before the edge, flags after it.
    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic ld);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; flag_load = ld;
        #1 res_seen = alu_out;
        @(negedge clk);
        flag_load = 1'b0;
    endtask

    // exp_f is {C,S,Z,V}
    task automatic expect_op(input string tag, input logic [4:0] op, input logic [7:0] a,
                             input logic [7:0] b, input logic [7:0] exp_r,
                             input logic [3:0] exp_f);
        drive(op, a, b, 1'b1);
        check({tag, " result"}, 32'(res_seen), 32'(exp_r));
        check({tag, " flags CSZV"}, 32'(flags_now), 32'(exp_f));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 flags in reset", 32'(flags_now), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_add;
        expect_op("R4 ADD 7F+01",  ADD, 8'h7F, 8'h01, 8'h80, 4'b0101);
        expect_op("R3 ADD FF+01",  ADD, 8'hFF, 8'h01, 8'h00, 4'b1010);
        expect_op("R4 ADD 80+80",  ADD, 8'h80, 8'h80, 8'h00, 4'b1011);
        expect_op("R3 ADC 10+20+C", ADC, 8'h10, 8'h20, 8'h31, 4'b0000);
    endtask

    task automatic t_sub;
        expect_op("R3 SUB 05-03",  SUB, 8'h05, 8'h03, 8'h02, 4'b1000);
        expect_op("R3 SUB 03-05",  SUB, 8'h03, 8'h05, 8'hFE, 4'b0100);
        expect_op("R3 SBB C=0",    SBB, 8'h10, 8'h01, 8'h0E, 4'b1000);
        expect_op("R4 SUB 80-01",  SUB, 8'h80, 8'h01, 8'h7F, 4'b1001);
        expect_op("R3 SBB C=1",    SBB, 8'h00, 8'h00, 8'h00, 4'b1010);
    endtask

    task automatic t_unary;
        expect_op("R6 INC 7F", INC, 8'h7F, 8'h00, 8'h80, 4'b0101);
        expect_op("R6 INC FF", INC, 8'hFF, 8'h00, 8'h00, 4'b1010);
        expect_op("R6 DEC 00", DEC, 8'h00, 8'h00, 8'hFF, 4'b0100);
        expect_op("R6 DEC 80", DEC, 8'h80, 8'h00, 8'h7F, 4'b1001);
        expect_op("R6 NEG 80", NEG, 8'h80, 8'h00, 8'h80, 4'b0101);
        expect_op("R6 NEG 01", NEG, 8'h01, 8'h00, 8'hFF, 4'b0100);
        expect_op("R6 NEG 00", NEG, 8'h00, 8'h00, 8'h00, 4'b1010);
    endtask

    task automatic t_logic;
        expect_op("R7 preset V",   ADD, 8'h7F, 8'h01, 8'h80, 4'b0101);
        expect_op("R11 STC",       STC, 8'h33, 8'h00, 8'h33, 4'b1101);
        expect_op("R7 AND clears V keeps C", AND, 8'hF0, 8'h0F, 8'h00, 4'b1010);
        expect_op("R7 OR",         OR_, 8'h80, 8'h01, 8'h81, 4'b1100);
        expect_op("R7 NOT",        NOT, 8'h0F, 8'h55, 8'hF0, 4'b1100);
        expect_op("R7 CLR",        CLR, 8'hA5, 8'h5A, 8'h00, 4'b1010);
        expect_op("R11 CLC",       CLC, 8'h00, 8'h00, 8'h00, 4'b0010);
    endtask

    task automatic t_compare;
        expect_op("R8 XOR equal",    XOR, 8'h5A, 8'h5A, 8'h00, 4'b0010);
        expect_op("R8 XOR unequal",  XOR, 8'h5A, 8'h5B, 8'h01, 4'b0000);
        expect_op("R8 AND bit clear", AND, 8'hFB, 8'h04, 8'h00, 4'b0010);
        expect_op("R8 AND bit set",  AND, 8'h04, 8'h04, 8'h04, 4'b0000);
    endtask

    task automatic t_shift;
        expect_op("R9 SHR 81",  SHR, 8'h81, 8'h00, 8'h40, 4'b1000);
        expect_op("R9 SHL 81",  SHL, 8'h81, 8'h00, 8'h02, 4'b1000);
        expect_op("R9 SAR 81",  SAR, 8'h81, 8'h00, 8'hC0, 4'b1100);
        expect_op("R9 SAL 40",  SAL, 8'h40, 8'h00, 8'h80, 4'b0101);
        expect_op("R9 SAL C0",  SAL, 8'hC0, 8'h00, 8'h80, 4'b1100);
        expect_op("R9 SHL 40",  SHL, 8'h40, 8'h00, 8'h80, 4'b0100);
    endtask

    task automatic t_rotate;
        expect_op("R10 ROR 01",     ROR, 8'h01, 8'h00, 8'h80, 4'b1100);
        expect_op("R10 ROL 80",     ROL, 8'h80, 8'h00, 8'h01, 4'b1000);
        expect_op("R11 CLC",        CLC, 8'h00, 8'h00, 8'h00, 4'b0000);
        expect_op("R10 RCR 01 C=0", RCR, 8'h01, 8'h00, 8'h00, 4'b1010);
        expect_op("R10 RCR 00 C=1", RCR, 8'h00, 8'h00, 8'h80, 4'b0100);
        expect_op("R10 RCL 80 C=0", RCL, 8'h80, 8'h00, 8'h00, 4'b1010);
        expect_op("R10 RCL 00 C=1", RCL, 8'h00, 8'h00, 8'h01, 4'b0000);
    endtask

    task automatic t_carry_ops;
        expect_op("R11 preset",  ADD, 8'h7F, 8'h01, 8'h80, 4'b0101);
        expect_op("R11 CMC 0->1", CMC, 8'h00, 8'h11, 8'h00, 4'b1101);
        expect_op("R11 CMC 1->0", CMC, 8'h9C, 8'h00, 8'h9C, 4'b0101);
        expect_op("R11 STC",      STC, 8'h00, 8'h00, 8'h00, 4'b1101);
        expect_op("R11 CLC",      CLC, 8'h42, 8'h00, 8'h42, 4'b0101);
    endtask

    task automatic t_hold;
        drive(ADD, 8'hFF, 8'h01, 1'b0);
        check("R2 result without load", 32'(res_seen), 32'h00);
        check("R2 flags held without load", 32'(flags_now), 32'b0101);
        drive(NEG, 8'h00, 8'h00, 1'b0);
        check("R2 flags held after NEG unloaded", 32'(flags_now), 32'b0101);
    endtask

    task automatic t_reserved;
        expect_op("R12 op 23", 5'd23, 8'h3C, 8'hFF, 8'h3C, 4'b0101);
        expect_op("R12 op 31", 5'd31, 8'h00, 8'h01, 8'h00, 4'b0101);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        #2;
        t_reset();
        t_add();
        t_sub();
        t_unary();
        t_logic();
        t_compare();
        t_shift();
        t_rotate();
        t_carry_ops();
        t_hold();
        t_reserved();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule